// File: doc/BRIEF.md
# Instance memory region decoder

This block sits in front of a graphics instance-memory aperture and decides where each access goes. Three special regions can be placed inside the low 64 KiB of the aperture: an object hash table, a FIFO context store and a runout buffer for rejected submissions. Every other address goes to plain backing memory. Software places the regions by writing three configuration words. Each word gives a region base and, for two of the regions, a size.

Each request first passes through an address reversal stage. The aperture is mirrored in 16-byte units by XOR with (memory size − 16). The reversed address is then compared against the three windows. When windows overlap, a fixed priority picks the winner. The request is driven to exactly one of four ports with its write flag, byte enables and write data unchanged. Read data from the selected port is returned through one registered response stage.

Top module: `imem_region_decoder`

## Requirements
- R1: After reset all three configuration words are zero. The hash table then covers effective addresses 0x0000–0x0FFF and wins over the other regions there, so effective 0x0800 goes to the hash port and effective 0x1000 goes to generic memory.
- R2: Configuration select 0 writes the hash-table word. Bits [15:12] are the base (start = base << 12). Bits [17:16] are the size: 0, 1, 2 and 3 give 4, 8, 16 and 32 KiB.
- R3: Configuration select 1 writes the context-store word. Bits [15:9] are the base (start = base << 9). The length is fixed at 0x1000 bytes.
- R4: Configuration select 2 writes the runout word. Bits [15:9] are the base (start = base << 9). Bit 16 is the size: 0 gives 512 bytes and 1 gives 8 KiB.
- R5: A region matches when start ≤ address < start + length. The hash table has priority over the context store, which has priority over the runout buffer. An address that matches no region goes to generic memory.
- R6: An effective address at or above 0x10000 always goes to generic memory, even when a window computed from the configuration extends past 64 KiB.
- R7: The effective address is the request address XOR (MEM_BYTES − 16). It is presented on `out_addr`.
- R8: While a request is valid, exactly one of the four port selects is high. While no request is valid, none of them is high.
- R9: A read request raises `rsp_valid` in the following cycle, carrying the read data of the port that was selected. A write request produces no response.
- R10: A configuration write applies to requests in cycles after its clock edge. A request in the same cycle as the write is decoded with the old value.
- R11: The write flag, byte enables and write data of the request appear unchanged on `out_write`, `out_be` and `out_wdata`.
- R12: A configuration write with select 3 has no effect on any region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select: 0 hash, 1 context, 2 runout |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Aperture byte address before reversal |
| req_be | input | DATA_W/8 | Byte enables |
| req_wdata | input | DATA_W | Write data |
| ht_sel | output | 1 | Request steered to hash table |
| fc_sel | output | 1 | Request steered to context store |
| ro_sel | output | 1 | Request steered to runout buffer |
| mem_sel | output | 1 | Request steered to generic memory |
| out_addr | output | ADDR_W | Effective (reversed) address |
| out_write | output | 1 | Forwarded write flag |
| out_be | output | DATA_W/8 | Forwarded byte enables |
| out_wdata | output | DATA_W | Forwarded write data |
| ht_rdata | input | DATA_W | Read data from hash-table port |
| fc_rdata | input | DATA_W | Read data from context-store port |
| ro_rdata | input | DATA_W | Read data from runout port |
| mem_rdata | input | DATA_W | Read data from generic memory |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DATA_W | Read response data |

## Verification
A corrupted configuration field shows up on the next request after the write, as a select on the wrong port near that region's edges. For this reason the vectors probe the last byte inside each window and the first byte past it. A fault in the priority or the 64 KiB guard is visible in the same cycle as the request, as two selects high or a hit where generic memory was due. A stuck response register is seen one cycle later as a missing or extra `rsp_valid`, or as data from the wrong port.

// File: rtl/imrd_pkg.sv
package imrd_pkg;
  localparam int CFG_W    = 32;
  localparam int WIN_W    = 17;  // window math needs one bit above 64 KiB
  localparam int LOW_W    = 16;  // regions live inside the first 64 KiB
  localparam int NUM_RGN  = 3;

  // region index doubles as priority: lower index wins
  localparam int IDX_HT = 0;
  localparam int IDX_FC = 1;
  localparam int IDX_RO = 2;

  // configuration field positions decoded by this block
  localparam int HT_BASE_LSB = 12;
  localparam int HT_SIZE_LSB = 16;
  localparam int FC_BASE_LSB = 9;
  localparam int RO_BASE_LSB = 9;
  localparam int RO_SIZE_LSB = 16;

  localparam logic [WIN_W-1:0] FC_LEN     = 17'h01000;
  localparam logic [WIN_W-1:0] HT_LEN_MIN = 17'h01000;
  localparam logic [WIN_W-1:0] RO_LEN_SM  = 17'h00200;
  localparam logic [WIN_W-1:0] RO_LEN_LG  = 17'h02000;

  typedef struct packed {
    logic [3:0] base;
    logic [1:0] size;
  } ht_cfg_t;

  typedef struct packed {
    logic [6:0] base;
  } fc_cfg_t;

  typedef struct packed {
    logic [6:0] base;
    logic       size;
  } ro_cfg_t;

  typedef enum logic [1:0] {
    CSEL_HT  = 2'd0,
    CSEL_FC  = 2'd1,
    CSEL_RO  = 2'd2,
    CSEL_NOP = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/imrd_cfg_regs.sv
module imrd_cfg_regs
  import imrd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output ht_cfg_t          ht_cfg,
  output fc_cfg_t          fc_cfg,
  output ro_cfg_t          ro_cfg
);
  ht_cfg_t ht_d;
  fc_cfg_t fc_d;
  ro_cfg_t ro_d;
  logic    ht_en, fc_en, ro_en;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:18], cfg_wdata[8:0]};

  always_comb begin
    ht_en = cfg_we && (cfg_sel == CSEL_HT);
    fc_en = cfg_we && (cfg_sel == CSEL_FC);
    ro_en = cfg_we && (cfg_sel == CSEL_RO);
    ht_d.base = cfg_wdata[HT_BASE_LSB +: 4];
    ht_d.size = cfg_wdata[HT_SIZE_LSB +: 2];
    fc_d.base = cfg_wdata[FC_BASE_LSB +: 7];
    ro_d.base = cfg_wdata[RO_BASE_LSB +: 7];
    ro_d.size = cfg_wdata[RO_SIZE_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ht_cfg <= '0;
      fc_cfg <= '0;
      ro_cfg <= '0;
    end else begin
      if (ht_en) ht_cfg <= ht_d;
      if (fc_en) fc_cfg <= fc_d;
      if (ro_en) ro_cfg <= ro_d;
    end
  end
endmodule

// File: rtl/imrd_bounds.sv
module imrd_bounds
  import imrd_pkg::*;
(
  input  ht_cfg_t                         ht_cfg,
  input  fc_cfg_t                         fc_cfg,
  input  ro_cfg_t                         ro_cfg,
  output logic [NUM_RGN-1:0][WIN_W-1:0]   rgn_start,
  output logic [NUM_RGN-1:0][WIN_W-1:0]   rgn_limit
);
  logic [WIN_W-1:0] ht_len, ro_len;

  always_comb begin
    ht_len = HT_LEN_MIN << ht_cfg.size;
    ro_len = ro_cfg.size ? RO_LEN_LG : RO_LEN_SM;

    rgn_start[IDX_HT] = {1'b0, ht_cfg.base, 12'h000};
    rgn_start[IDX_FC] = {1'b0, fc_cfg.base, 9'h000};
    rgn_start[IDX_RO] = {1'b0, ro_cfg.base, 9'h000};

    rgn_limit[IDX_HT] = rgn_start[IDX_HT] + ht_len;
    rgn_limit[IDX_FC] = rgn_start[IDX_FC] + FC_LEN;
    rgn_limit[IDX_RO] = rgn_start[IDX_RO] + ro_len;
  end
endmodule

// File: rtl/imrd_window.sv
module imrd_window
  import imrd_pkg::*;
(
  input  logic             in_low,
  input  logic [LOW_W-1:0] addr_lo,
  input  logic [WIN_W-1:0] start,
  input  logic [WIN_W-1:0] limit,
  output logic             hit
);
  logic [WIN_W-1:0] a_ext;

  always_comb begin
    a_ext = {1'b0, addr_lo};
    hit   = in_low && (a_ext >= start) && (a_ext < limit);
  end
endmodule

// File: rtl/imrd_resp.sv
module imrd_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [3:0]        sel_vec,   // {ht, fc, ro, mem}
  input  logic [DATA_W-1:0] ht_rdata,
  input  logic [DATA_W-1:0] fc_rdata,
  input  logic [DATA_W-1:0] ro_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = ({DATA_W{sel_vec[3]}} & ht_rdata)
           | ({DATA_W{sel_vec[2]}} & fc_rdata)
           | ({DATA_W{sel_vec[1]}} & ro_rdata)
           | ({DATA_W{sel_vec[0]}} & mem_rdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= data_d;
    end
  end
endmodule

// File: rtl/imem_region_decoder.sv
module imem_region_decoder
  import imrd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 4194304,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int BE_W     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ht_sel,
  output logic              fc_sel,
  output logic              ro_sel,
  output logic              mem_sel,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_write,
  output logic [BE_W-1:0]   out_be,
  output logic [DATA_W-1:0] out_wdata,
  input  logic [DATA_W-1:0] ht_rdata,
  input  logic [DATA_W-1:0] fc_rdata,
  input  logic [DATA_W-1:0] ro_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam logic [ADDR_W-1:0] REV_MASK = ADDR_W'(MEM_BYTES - 16);

  ht_cfg_t ht_cfg;
  fc_cfg_t fc_cfg;
  ro_cfg_t ro_cfg;
  logic [NUM_RGN-1:0][WIN_W-1:0] rgn_start, rgn_limit;
  logic [NUM_RGN-1:0]            rgn_hit;
  logic [ADDR_W-1:0]             eff_addr;
  logic                          eff_low;

  imrd_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .ht_cfg    (ht_cfg),
    .fc_cfg    (fc_cfg),
    .ro_cfg    (ro_cfg)
  );

  imrd_bounds u_bnd (
    .ht_cfg    (ht_cfg),
    .fc_cfg    (fc_cfg),
    .ro_cfg    (ro_cfg),
    .rgn_start (rgn_start),
    .rgn_limit (rgn_limit)
  );

  // aperture mirror in 16-byte units
  always_comb begin
    eff_addr = req_addr ^ REV_MASK;
    eff_low  = ~|eff_addr[ADDR_W-1:LOW_W];
  end

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_win
    imrd_window u_win (
      .in_low  (eff_low),
      .addr_lo (eff_addr[LOW_W-1:0]),
      .start   (rgn_start[g]),
      .limit   (rgn_limit[g]),
      .hit     (rgn_hit[g])
    );
  end

  // fixed priority: hash table, then context store, then runout
  always_comb begin
    ht_sel  = req_valid &&  rgn_hit[IDX_HT];
    fc_sel  = req_valid && !rgn_hit[IDX_HT] &&  rgn_hit[IDX_FC];
    ro_sel  = req_valid && !rgn_hit[IDX_HT] && !rgn_hit[IDX_FC] && rgn_hit[IDX_RO];
    mem_sel = req_valid && ~|rgn_hit;
    out_addr  = eff_addr;
    out_write = req_write;
    out_be    = req_be;
    out_wdata = req_wdata;
  end

  imrd_resp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (req_valid && !req_write),
    .sel_vec   ({ht_sel, fc_sel, ro_sel, mem_sel}),
    .ht_rdata  (ht_rdata),
    .fc_rdata  (fc_rdata),
    .ro_rdata  (ro_rdata),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/imrd_checker.sv
module imrd_checker #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              ht_sel,
  input logic              fc_sel,
  input logic              ro_sel,
  input logic              mem_sel,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] ht_rdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata
);
  // R8: one port per valid request
  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({ht_sel, fc_sel, ro_sel, mem_sel}) == 1);

  // R8: no port while idle
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(ht_sel || fc_sel || ro_sel || mem_sel));

  // R6: addresses past 64 KiB go to generic memory
  assert_high_generic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (|out_addr[ADDR_W-1:16])) |-> mem_sel);

  // R9: reads answered next cycle
  assert_read_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R9: no response without a read
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R9: data from the selected port
  assert_ht_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && ht_sel) |=> rsp_rdata == $past(ht_rdata));

  assert_mem_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && mem_sel) |=> rsp_rdata == $past(mem_rdata));
endmodule

bind imem_region_decoder imrd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .ht_sel    (ht_sel),
  .fc_sel    (fc_sel),
  .ro_sel    (ro_sel),
  .mem_sel   (mem_sel),
  .out_addr  (out_addr),
  .ht_rdata  (ht_rdata),
  .mem_rdata (mem_rdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata)
);

// File: tb/sim_imem_region_decoder.sv
module sim_imem_region_decoder;
  localparam int MEM_BYTES = 4194304;
  localparam int ADDR_W    = 22;
  localparam int DATA_W    = 32;
  localparam logic [ADDR_W-1:0] REV = ADDR_W'(MEM_BYTES - 16);
  localparam logic [31:0] D_HT  = 32'hA1A1_0001;
  localparam logic [31:0] D_FC  = 32'hB2B2_0002;
  localparam logic [31:0] D_RO  = 32'hC3C3_0003;
  localparam logic [31:0] D_MEM = 32'hD4D4_0004;

  // expected code: 0 generic, 1 hash, 2 context, 3 runout
  typedef struct packed {
    logic [15:0] tag;
    logic [31:0] ht;
    logic [31:0] fc;
    logic [31:0] ro;
    logic [23:0] ea;
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{"R2", 32'h0000_3000, 32'h0000_0400, 32'h0000_A000, 24'h003FFF, 2'd1},
    '{"R2", 32'h0000_3000, 32'h0000_0400, 32'h0000_A000, 24'h004000, 2'd0},
    '{"R3", 32'h0000_3000, 32'h0000_0400, 32'h0000_A000, 24'h0013FF, 2'd2},
    '{"R3", 32'h0000_3000, 32'h0000_0400, 32'h0000_A000, 24'h001400, 2'd0},
    '{"R4", 32'h0000_3000, 32'h0000_0400, 32'h0000_A000, 24'h00A1FF, 2'd3},
    '{"R4", 32'h0000_3000, 32'h0000_0400, 32'h0000_A000, 24'h00A200, 2'd0},
    '{"R2", 32'h0003_3000, 32'h0000_0400, 32'h0000_A000, 24'h00AFFF, 2'd1},
    '{"R5", 32'h0003_3000, 32'h0000_0400, 32'h0000_A000, 24'h00A100, 2'd1},
    '{"R2", 32'h0003_3000, 32'h0000_0400, 32'h0000_A000, 24'h00B000, 2'd0},
    '{"R2", 32'h0001_3000, 32'h0000_0400, 32'h0000_A000, 24'h004FFF, 2'd1},
    '{"R2", 32'h0001_3000, 32'h0000_0400, 32'h0000_A000, 24'h005000, 2'd0},
    '{"R2", 32'h0002_3000, 32'h0000_0400, 32'h0000_A000, 24'h006FFF, 2'd1},
    '{"R2", 32'h0002_3000, 32'h0000_0400, 32'h0000_A000, 24'h007000, 2'd0},
    '{"R4", 32'h0000_3000, 32'h0000_0400, 32'h0001_A000, 24'h00BFFF, 2'd3},
    '{"R4", 32'h0000_3000, 32'h0000_0400, 32'h0001_A000, 24'h00C000, 2'd0},
    '{"R5", 32'h0000_3000, 32'h0000_3800, 32'h0000_4000, 24'h003800, 2'd1},
    '{"R5", 32'h0000_3000, 32'h0000_3800, 32'h0000_4000, 24'h004100, 2'd2},
    '{"R5", 32'h0000_3000, 32'h0000_3800, 32'h0000_4000, 24'h004200, 2'd2},
    '{"R6", 32'h0003_F000, 32'h0000_3800, 32'h0000_4000, 24'h010000, 2'd0},
    '{"R6", 32'h0003_F000, 32'h0000_3800, 32'h0000_4000, 24'h00FFFF, 2'd1}
  };

  logic              clk, rst_n;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [31:0]       cfg_wdata;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [3:0]        req_be;
  logic [DATA_W-1:0] req_wdata;
  logic              ht_sel, fc_sel, ro_sel, mem_sel;
  logic [ADDR_W-1:0] out_addr;
  logic              out_write;
  logic [3:0]        out_be;
  logic [DATA_W-1:0] out_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;

  imem_region_decoder #(.DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .ht_sel(ht_sel), .fc_sel(fc_sel), .ro_sel(ro_sel), .mem_sel(mem_sel),
    .out_addr(out_addr), .out_write(out_write), .out_be(out_be),
    .out_wdata(out_wdata), .ht_rdata(D_HT), .fc_rdata(D_FC),
    .ro_rdata(D_RO), .mem_rdata(D_MEM), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] onehot_of(input logic [1:0] code);
    case (code)
      2'd1:    return 4'b1000;
      2'd2:    return 4'b0100;
      2'd3:    return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [31:0] data_of(input logic [1:0] code);
    case (code)
      2'd1:    return D_HT;
      2'd2:    return D_FC;
      2'd3:    return D_RO;
      default: return D_MEM;
    endcase
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one request; checks steering at once and the response after the edge
  task automatic access(input logic [23:0] ea, input bit wr,
                        input logic [1:0] code, input string req);
    logic [31:0] wd;
    wd = 32'h5A00_0000 ^ 32'(ea);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_addr  = ADDR_W'(ea) ^ REV;
    req_be    = 4'b0110; req_wdata = wd;
    #1;
    chk({ht_sel, fc_sel, ro_sel, mem_sel} == onehot_of(code), req,
        64'({ht_sel, fc_sel, ro_sel, mem_sel}), 64'(onehot_of(code)));
    chk(out_addr == ADDR_W'(ea), "R7 reversed address", 64'(out_addr), 64'(ea));
    chk(out_write == wr && out_be == 4'b0110 && out_wdata == wd, "R11 forward",
        {27'd0, out_write, out_be, out_wdata}, {27'd0, wr, 4'b0110, wd});
    @(posedge clk);
    #1;
    if (wr) begin
      chk(!rsp_valid, "R9 no response to write", 64'(rsp_valid), 64'd0);
    end else begin
      chk(rsp_valid && rsp_rdata == data_of(code), "R9 read response",
          {31'd0, rsp_valid, rsp_rdata}, {31'd0, 1'b1, data_of(code)});
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_be = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rsp_valid, "R1 reset response", 64'(rsp_valid), 64'd0);
    chk({ht_sel, fc_sel, ro_sel, mem_sel} == 4'b0000, "R8 idle in reset",
        64'({ht_sel, fc_sel, ro_sel, mem_sel}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: zero configuration after reset
    access(24'h000800, 1'b0, 2'd1, "R1 reset hash window");
    access(24'h001000, 1'b0, 2'd0, "R1 reset past windows");
    go_idle();
    #1;
    chk({ht_sel, fc_sel, ro_sel, mem_sel} == 4'b0000, "R8 idle no select",
        64'({ht_sel, fc_sel, ro_sel, mem_sel}), 64'd0);

    // table walk: R2 R3 R4 R5 R6 windows and priority
    for (int i = 0; i < NV; i++) begin
      cfg_write(2'd0, VEC[i].ht);
      cfg_write(2'd1, VEC[i].fc);
      cfg_write(2'd2, VEC[i].ro);
      access(VEC[i].ea, 1'b0, VEC[i].code, $sformatf("%s vector %0d", VEC[i].tag, i));
      go_idle();
    end

    // R9: write gets no response
    access(24'h00FFFF, 1'b1, 2'd1, "R9 write steering");
    go_idle();

    // R10: write and request in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0000_5000;
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(24'h005000) ^ REV;
    #1;
    chk(mem_sel && !ht_sel, "R10 old config same cycle",
        64'({ht_sel, mem_sel}), 64'b01);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk(ht_sel && !mem_sel, "R10 new config next cycle",
        64'({ht_sel, mem_sel}), 64'b10);
    go_idle();

    // R12: select 3 is ignored
    cfg_write(2'd3, 32'hFFFF_FFFF);
    access(24'h005000, 1'b0, 2'd1, "R12 hash unchanged");
    access(24'h006000, 1'b0, 2'd0, "R12 hash size unchanged");
    access(24'h004100, 1'b0, 2'd2, "R12 context unchanged");
    go_idle();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule